// File: doc/BRIEF.md
# Memory-Destination Instruction Executor

This block is a small multicycle execution engine for an 8-bit accumulator machine. It runs only the instructions whose result lands in a data-RAM cell or a register-space (I/O) location instead of the accumulator. It fetches opcode and operand bytes from a byte-wide program memory. For the add forms it performs a read-modify-write on the data RAM port. For the move forms it issues a plain write on a separate register-space port.

The engine holds the accumulator, the index register, a program counter and carry/zero flags. The accumulator and index register take their values from the `aInit` and `xInit` inputs while reset is held. They are then constant, because none of the supported instructions writes them. The destination is named in one of two ways: by an address byte taken directly from the instruction, or by an offset byte added to the index register. The source is the accumulator or an immediate byte carried in the instruction. An opcode outside the supported set freezes the engine and raises a flag until the next reset.

Top module: `dest_exec_unit`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the engine returns to its initial state: `pcOut` 0, flags 0, no read or write strobe, `illegalOp` low, `accOut`=`aInit` and `xOut`=`xInit`.
- R2: Opcode 0x04 with operand d reads RAM[d] and writes RAM[d]+A (mod 256) back to d. The write follows the read by one cycle on the same address. RAM reads return data one cycle after `ramRdEn`. A and X never change after reset.
- R3: Opcode 0x05 with operand o does the same read-modify-write at address (X+o) mod 256.
- R4: Opcode 0x06 with operands d, k is three bytes long and writes RAM[d]+k (mod 256) back to d.
- R5: Opcode 0x60 with operand d writes A to register-space address d and does not touch RAM. No two of RAM read, RAM write and register write are asserted in the same cycle.
- R6: Opcode 0x62 with operands d, k writes k to register-space address d.
- R7: Each add sets carry to bit 8 of the 9-bit sum and sets zero when the stored 8-bit result is 0. Flags change only in the cycle after a RAM write.
- R8: The move opcodes (0x60, 0x62) leave carry and zero unchanged.
- R9: The program counter advances by the instruction length after each instruction: 2 for 0x04, 0x05 and 0x60, and 3 for 0x06 and 0x62. The next opcode is read from the new address. Program reads return data one cycle after the address is presented. The counter never changes by any other amount.
- R10: Any other opcode value raises `illegalOp`, which then stays high until reset. The engine stops: no further RAM read, RAM write or register write, and `pcOut` stays at the address of the offending opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| aInit | input | 8 | Accumulator value loaded during reset |
| xInit | input | 8 | Index register value loaded during reset |
| progAddr | output | PC_W | Program memory byte address |
| progData | input | 8 | Program byte, valid one cycle after its address |
| ramAddr | output | 8 | Data RAM address for read and write |
| ramRdEn | output | 1 | Data RAM read strobe |
| ramRdData | input | 8 | Data RAM read data, valid one cycle after the strobe |
| ramWrEn | output | 1 | Data RAM write strobe |
| ramWrData | output | 8 | Data RAM write data |
| regAddr | output | 8 | Register-space address |
| regWrEn | output | 1 | Register-space write strobe |
| regWrData | output | 8 | Register-space write data |
| pcOut | output | PC_W | Program counter |
| accOut | output | 8 | Accumulator |
| xOut | output | 8 | Index register |
| carryOut | output | 1 | Carry flag |
| zeroOut | output | 1 | Zero flag |
| illegalOp | output | 1 | Unsupported opcode seen, engine halted |

## Verification
A wrong decoded instruction class shows up at the ports within the same instruction, in one of three ways: a write to the wrong port, a write to the wrong address, or the wrong program counter step. A stale operand or a wrong source select corrupts the single RAM byte or register write that the instruction produces. Each sweep vector ends on a halt byte, so a length error moves the halt address seen on `pcOut` within a handful of cycles. Flag errors stay latched, so they remain visible through a following move instruction.

// File: rtl/dest_exec_pkg.sv
package dest_exec_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t OPC_ADD_DIRECT  = 8'h04;
  localparam byte_t OPC_ADD_INDEXED = 8'h05;
  localparam byte_t OPC_ADD_IMM     = 8'h06;
  localparam byte_t OPC_MOV_REG_A   = 8'h60;
  localparam byte_t OPC_MOV_REG_IMM = 8'h62;

  localparam logic [1:0] LEN_SHORT = 2'd2;
  localparam logic [1:0] LEN_LONG  = 2'd3;

  // Instruction class derived from the opcode byte
  typedef struct packed {
    logic legal;
    logic isAdd;    // read-modify-write on RAM, else register-space write
    logic indexed;  // destination = X + operand 1
    logic immSrc;   // source = operand 2 (three-byte form)
  } decode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] progOfs;   // program address = pc + progOfs
    logic       latchOp1;
    logic       latchOp2;
    logic       ramRd;
    logic       ramWr;
    logic       regWr;
    logic       useIdx;
    logic       useImm;
    logic [1:0] pcStep;
    logic       flagUpd;
  } strobe_t;

  function automatic decode_t decodeOpcode(byte_t opc);
    decode_t d;
    d = '0;
    unique case (opc)
      OPC_ADD_DIRECT:  d = '{legal: 1'b1, isAdd: 1'b1, indexed: 1'b0, immSrc: 1'b0};
      OPC_ADD_INDEXED: d = '{legal: 1'b1, isAdd: 1'b1, indexed: 1'b1, immSrc: 1'b0};
      OPC_ADD_IMM:     d = '{legal: 1'b1, isAdd: 1'b1, indexed: 1'b0, immSrc: 1'b1};
      OPC_MOV_REG_A:   d = '{legal: 1'b1, isAdd: 1'b0, indexed: 1'b0, immSrc: 1'b0};
      OPC_MOV_REG_IMM: d = '{legal: 1'b1, isAdd: 1'b0, indexed: 1'b0, immSrc: 1'b1};
      default:         d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dex_control.sv
module dex_control
  import dest_exec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  byte_t   progData,
  output strobe_t strb,
  output logic    halted
);

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_OPER1, S_OPER2, S_EXEC, S_WBACK, S_HALT
  } state_t;

  state_t  state, stateNext;
  decode_t dec, decNow;
  logic [1:0] instLen;

  assign decNow  = decodeOpcode(progData);
  assign instLen = dec.immSrc ? LEN_LONG : LEN_SHORT;
  assign halted  = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_FETCH;
      dec   <= '0;
    end else begin
      state <= stateNext;
      if (state == S_DECODE) dec <= decNow;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_FETCH: begin
        strb.progOfs = 2'd0;
        stateNext    = S_DECODE;
      end
      S_DECODE: begin
        strb.progOfs = 2'd1;
        stateNext    = decNow.legal ? S_OPER1 : S_HALT;
      end
      S_OPER1: begin
        strb.latchOp1 = 1'b1;
        strb.progOfs  = 2'd2;
        stateNext     = dec.immSrc ? S_OPER2 : S_EXEC;
      end
      S_OPER2: begin
        strb.latchOp2 = 1'b1;
        stateNext     = S_EXEC;
      end
      S_EXEC: begin
        strb.useIdx = dec.indexed;
        strb.useImm = dec.immSrc;
        if (dec.isAdd) begin
          strb.ramRd = 1'b1;
          stateNext  = S_WBACK;
        end else begin
          strb.regWr  = 1'b1;
          strb.pcStep = instLen;
          stateNext   = S_FETCH;
        end
      end
      S_WBACK: begin
        strb.useIdx  = dec.indexed;
        strb.useImm  = dec.immSrc;
        strb.ramWr   = 1'b1;
        strb.flagUpd = 1'b1;
        strb.pcStep  = instLen;
        stateNext    = S_FETCH;
      end
      S_HALT: stateNext = S_HALT;
      default: stateNext = S_HALT;
    endcase
  end

endmodule

// File: rtl/dex_datapath.sv
module dex_datapath
  import dest_exec_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  byte_t           aInit,
  input  byte_t           xInit,
  input  strobe_t         strb,
  input  byte_t           progData,
  input  byte_t           ramRdData,
  output logic [PC_W-1:0] progAddr,
  output byte_t           ramAddr,
  output byte_t           ramWrData,
  output byte_t           regAddr,
  output byte_t           regWrData,
  output logic [PC_W-1:0] pcOut,
  output byte_t           accOut,
  output byte_t           xOut,
  output logic            carryOut,
  output logic            zeroOut
);

  localparam int SUM_W = $bits(byte_t) + 1;

  logic [PC_W-1:0] pc;
  byte_t accA, idxX, oper1, oper2;
  logic  carry, zero;
  byte_t destAddr, srcVal;
  logic [SUM_W-1:0] sum;

  assign destAddr = strb.useIdx ? byte_t'(idxX + oper1) : oper1;
  assign srcVal   = strb.useImm ? oper2 : accA;
  assign sum      = {1'b0, ramRdData} + {1'b0, srcVal};

  assign progAddr  = pc + PC_W'(strb.progOfs);
  assign ramAddr   = destAddr;
  assign ramWrData = sum[SUM_W-2:0];
  assign regAddr   = destAddr;
  assign regWrData = srcVal;
  assign pcOut     = pc;
  assign accOut    = accA;
  assign xOut      = idxX;
  assign carryOut  = carry;
  assign zeroOut   = zero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= '0;
      accA  <= aInit;
      idxX  <= xInit;
      oper1 <= '0;
      oper2 <= '0;
      carry <= 1'b0;
      zero  <= 1'b0;
    end else begin
      if (strb.latchOp1) oper1 <= progData;
      if (strb.latchOp2) oper2 <= progData;
      pc <= pc + PC_W'(strb.pcStep);
      if (strb.flagUpd) begin
        carry <= sum[SUM_W-1];
        zero  <= (sum[SUM_W-2:0] == '0);
      end
    end
  end

endmodule

// File: rtl/dest_exec_unit.sv
module dest_exec_unit
  import dest_exec_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      aInit,
  input  logic [7:0]      xInit,
  output logic [PC_W-1:0] progAddr,
  input  logic [7:0]      progData,
  output logic [7:0]      ramAddr,
  output logic            ramRdEn,
  input  logic [7:0]      ramRdData,
  output logic            ramWrEn,
  output logic [7:0]      ramWrData,
  output logic [7:0]      regAddr,
  output logic            regWrEn,
  output logic [7:0]      regWrData,
  output logic [PC_W-1:0] pcOut,
  output logic [7:0]      accOut,
  output logic [7:0]      xOut,
  output logic            carryOut,
  output logic            zeroOut,
  output logic            illegalOp
);

  strobe_t strb;

  dex_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .progData (progData),
    .strb     (strb),
    .halted   (illegalOp)
  );

  dex_datapath #(.PC_W(PC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .aInit     (aInit),
    .xInit     (xInit),
    .strb      (strb),
    .progData  (progData),
    .ramRdData (ramRdData),
    .progAddr  (progAddr),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .pcOut     (pcOut),
    .accOut    (accOut),
    .xOut      (xOut),
    .carryOut  (carryOut),
    .zeroOut   (zeroOut)
  );

  assign ramRdEn = strb.ramRd;
  assign ramWrEn = strb.ramWr;
  assign regWrEn = strb.regWr;

endmodule

// File: rtl/dest_exec_checker.sv
module dest_exec_checker #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [7:0]      ramAddr,
  input logic            ramRdEn,
  input logic            ramWrEn,
  input logic            regWrEn,
  input logic [PC_W-1:0] pcOut,
  input logic [7:0]      accOut,
  input logic [7:0]      xOut,
  input logic            carryOut,
  input logic            zeroOut,
  input logic            illegalOp
);

  // R2: a RAM write always follows a read of the same cell
  p_rmw_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> ($past(ramRdEn) && ramAddr == $past(ramAddr)));

  // R2: accumulator and index register never move after reset
  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $stable(accOut) && $stable(xOut));

  // R5: at most one memory-side strobe per cycle
  p_one_access_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramRdEn, ramWrEn, regWrEn}));

  // R7 / R8: flags move only right after an add writes RAM
  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    (carryOut != $past(carryOut) || zeroOut != $past(zeroOut)) |-> $past(ramWrEn));

  // R9: program counter steps only by an instruction length
  p_pc_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pcOut != $past(pcOut)) |->
      (pcOut == $past(pcOut) + PC_W'(2) || pcOut == $past(pcOut) + PC_W'(3)));

  // R10: halt is sticky
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |=> illegalOp);

  // R10: halted engine issues no accesses and keeps its counter
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (!ramRdEn && !ramWrEn && !regWrEn && $stable(pcOut)));

endmodule

bind dest_exec_unit dest_exec_checker #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ramAddr   (ramAddr),
  .ramRdEn   (ramRdEn),
  .ramWrEn   (ramWrEn),
  .regWrEn   (regWrEn),
  .pcOut     (pcOut),
  .accOut    (accOut),
  .xOut      (xOut),
  .carryOut  (carryOut),
  .zeroOut   (zeroOut),
  .illegalOp (illegalOp)
);

// File: tb/test_dest_exec_unit.sv
`timescale 1ns/1ps
module test_dest_exec_unit;

  localparam int PC_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] aInit = '0, xInit = '0;
  logic [PC_W-1:0] progAddr, pcOut;
  logic [7:0] progData = '0, ramRdData = '0;
  logic [7:0] ramAddr, ramWrData, regAddr, regWrData, accOut, xOut;
  logic ramRdEn, ramWrEn, regWrEn, carryOut, zeroOut, illegalOp;

  always #4 clk = ~clk;

  dest_exec_unit #(.PC_W(PC_W)) i_dest_exec_unit (
    .clk(clk), .rstN(rstN), .aInit(aInit), .xInit(xInit),
    .progAddr(progAddr), .progData(progData),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn), .ramWrData(ramWrData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .pcOut(pcOut), .accOut(accOut), .xOut(xOut),
    .carryOut(carryOut), .zeroOut(zeroOut), .illegalOp(illegalOp)
  );

  // Memory models
  logic [7:0] prog [256];
  logic [7:0] ram  [256];
  logic       tbRamWe = 1'b0, tbClr = 1'b0;
  logic [7:0] tbRamAddr = '0, tbRamData = '0;
  int ramWrCnt, ramRdCnt, regWrCnt;
  logic [7:0] regLastAddr, regLastData;

  always @(posedge clk) begin
    progData <= prog[progAddr];
    if (ramRdEn) ramRdData <= ram[ramAddr];
    if (tbRamWe) ram[tbRamAddr] <= tbRamData;
    else if (ramWrEn) ram[ramAddr] <= ramWrData;
    if (tbClr) begin
      ramWrCnt <= 0; ramRdCnt <= 0; regWrCnt <= 0;
      regLastAddr <= '0; regLastData <= '0;
    end else begin
      if (ramWrEn) ramWrCnt <= ramWrCnt + 1;
      if (ramRdEn) ramRdCnt <= ramRdCnt + 1;
      if (regWrEn) begin
        regWrCnt    <= regWrCnt + 1;
        regLastAddr <= regAddr;
        regLastData <= regWrData;
      end
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic prepare(logic [7:0] a, logic [7:0] x, logic [7:0] addr, logic [7:0] val);
    @(negedge clk);
    rstN = 1'b0; aInit = a; xInit = x;
    tbRamWe = 1'b1; tbRamAddr = addr; tbRamData = val; tbClr = 1'b1;
    @(negedge clk);
    tbRamWe = 1'b0; tbClr = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitHalt();
    for (int i = 0; i < 40 && !illegalOp; i++) @(negedge clk);
  endtask

  function automatic bit isLegal(int op);
    return op == 8'h04 || op == 8'h05 || op == 8'h06 || op == 8'h60 || op == 8'h62;
  endfunction

  task automatic addCase(int opc, int a, int x, int b1, int b2, int m, string req);
    int len, dest, src, sum;
    len  = (opc == 8'h06) ? 3 : 2;
    dest = (opc == 8'h05) ? ((x + b1) & 255) : b1;
    src  = (opc == 8'h06) ? b2 : a;
    sum  = m + src;
    prog[0] = 8'(opc); prog[1] = 8'(b1);
    prog[2] = (len == 3) ? 8'(b2) : 8'hFF;
    prog[3] = 8'hFF;
    prepare(8'(a), 8'(x), 8'(dest), 8'(m));
    waitHalt();
    chk(req, "ram result", ram[dest], sum & 255);
    chk("R7", "carry", carryOut, sum >> 8);
    chk("R7", "zero", zeroOut, ((sum & 255) == 0) ? 1 : 0);
    chk("R9", "pc after add", pcOut, len);
    chk(req, "ram writes", ramWrCnt, 1);
    chk(req, "reg writes", regWrCnt, 0);
    chk("R2", "acc unchanged", accOut, a);
  endtask

  task automatic movCase(int opc, int a, int b1, int b2);
    int len, src;
    len = (opc == 8'h62) ? 3 : 2;
    src = (opc == 8'h62) ? b2 : a;
    prog[0] = 8'(opc); prog[1] = 8'(b1);
    prog[2] = (len == 3) ? 8'(b2) : 8'hFF;
    prog[3] = 8'hFF;
    prepare(8'(a), 8'h33, 8'(b1), 8'h5A);
    waitHalt();
    chk((opc == 8'h62) ? "R6" : "R5", "reg write count", regWrCnt, 1);
    chk((opc == 8'h62) ? "R6" : "R5", "reg addr", regLastAddr, b1);
    chk((opc == 8'h62) ? "R6" : "R5", "reg data", regLastData, src);
    chk("R5", "ram untouched", ram[b1], 8'h5A);
    chk("R5", "ram writes", ramWrCnt, 0);
    chk("R9", "pc after mov", pcOut, len);
  endtask

  task automatic flagKeep(int movOpc, int m, int k, int expC, int expZ);
    int movLen;
    movLen = (movOpc == 8'h62) ? 3 : 2;
    prog[0] = 8'h06; prog[1] = 8'h10; prog[2] = 8'(k);
    prog[3] = 8'(movOpc); prog[4] = 8'h21; prog[5] = 8'h77;
    prog[3 + movLen] = 8'hFF;
    prepare(8'h0C, 8'h00, 8'h10, 8'(m));
    waitHalt();
    chk("R8", "carry kept", carryOut, expC);
    chk("R8", "zero kept", zeroOut, expZ);
    chk("R9", "pc after pair", pcOut, 3 + movLen);
    chk("R8", "mov executed", regWrCnt, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin prog[i] = 8'hFF; ram[i] = 8'h00; end

    // R1: reset state
    aInit = 8'hA5; xInit = 8'h3C; rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc", pcOut, 0);
    chk("R1", "illegal", illegalOp, 0);
    chk("R1", "strobes", {ramRdEn, ramWrEn, regWrEn}, 0);
    chk("R1", "flags", {carryOut, zeroOut}, 0);
    chk("R1", "acc", accOut, 8'hA5);
    chk("R1", "x", xOut, 8'h3C);

    // R2 / R3 / R4: add sweeps
    for (int i = 0; i < 18; i++) begin
      for (int j = 0; j < 16; j++) begin
        addCase(8'h04, (i * 15) & 255, 0, (j * 29 + 1) & 255, 0, (j * 17) & 255, "R2");
        addCase(8'h05, (i * 15 + 7) & 255, (i * 37 + 3) & 255,
                (j * 53 + 200) & 255, 0, (j * 17 + 5) & 255, "R3");
        addCase(8'h06, (i * 11) & 255, 0, (i * 7 + j) & 255, (i * 15) & 255,
                (j * 17) & 255, "R4");
      end
    end
    // R3: explicit wrap of X + offset
    addCase(8'h05, 8'h01, 8'hF0, 8'h20, 0, 8'hFF, "R3");

    // R5 / R6: register-space moves
    for (int i = 0; i < 16; i++) begin
      movCase(8'h60, (i * 17 + 1) & 255, (i * 13 + 2) & 255, 0);
      movCase(8'h62, (i * 9) & 255, (i * 31 + 4) & 255, (i * 23 + 6) & 255);
    end

    // R8: flags survive moves, all four flag combinations
    flagKeep(8'h60, 8'h80, 8'h80, 1, 1);
    flagKeep(8'h62, 8'hF0, 8'h20, 1, 0);
    flagKeep(8'h60, 8'h00, 8'h00, 0, 1);
    flagKeep(8'h62, 8'h01, 8'h02, 0, 0);

    // R10: every unsupported opcode halts at once
    for (int op = 0; op < 256; op++) begin
      if (!isLegal(op)) begin
        prog[0] = 8'(op); prog[1] = 8'h04; prog[2] = 8'h04; prog[3] = 8'h04;
        prepare(8'h11, 8'h22, 8'h04, 8'h00);
        repeat (12) @(negedge clk);
        chk("R10", "illegal raised", illegalOp, 1);
        chk("R10", "pc frozen", pcOut, 0);
        chk("R10", "no accesses", ramRdCnt + ramWrCnt + regWrCnt, 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule